// File: doc/BRIEF.md
# Single-Slope Ramp Conversion Sequencer

This block turns comparator transition times into calibrated voltage codes for a sixteen-channel single-slope digitizer. Every channel's comparator watches the same shared reference. The reference climbs for 4096 time steps and then falls for the rest of a 500 ns conversion cycle. A time-to-digital front end supplies integer timestamps in 100 ps steps for each comparator edge, and a separate timestamp for the start of each cycle.

For every channel and every cycle the block keeps the first leading edge seen while the ramp rises and the first trailing edge seen while it falls. It turns each elapsed time into a 12-bit code through a piecewise-linear calibration table, so a nonlinear ramp can be corrected. When the next cycle starts, the block streams the finished cycle out over a valid/ready port as 32 tagged samples. Each sample carries the channel, the ramp direction, and either a code or an overflow flag. Extra edges count as glitches in a saturating counter per channel. A select input reads that counter back.

Top module: `ramp_seq`

## Requirements
- R1: Elapsed time is `ev_ts - start timestamp`, taken modulo 2^16. An elapsed time below 4096 lies in the rising phase and uses t = elapsed. Otherwise the event lies in the falling phase and uses t = elapsed - 4096, clamped to 4095.
- R2: Only a leading edge (`ev_lead`=1) is captured in the rising phase, and only a trailing edge (`ev_lead`=0) in the falling phase. An edge of the other polarity is ignored and does not count as a glitch.
- R3: Per channel and phase, the first matching edge is kept. Each later matching edge adds one to that channel's glitch counter instead. The counter resets to 0, saturates at 255, and appears on `glitch_cnt` for the channel on `glitch_ch`.
- R4: A channel/phase with no captured edge yields a sample with `m_ovf`=1 and `m_code`=0.
- R5: At each `cyc_start` after the first, the cycle just finished is offered. `m_valid` goes high on the next clock. The 32 samples come in the order ch0 rise, ch0 fall, ch1 rise, and so on up to ch15 fall, with `m_dir`=0 for rise and 1 for fall.
- R6: A sample with `m_valid` high and `m_ready` low stays unchanged. Each clock with both high moves to the next sample. `m_valid` drops after the 32nd transfer.
- R7: With seg = t[11:8], f = t[7:0], and y0, y1 the entries seg and seg+1 of the direction's table, the code is y0 + floor((y1-y0)*f/256).
- R8: After reset, entry k of both tables holds min(256*k, 4095), for k from 0 to 16. A write with `cal_we`=1 sets entry `cal_idx` of table `cal_dir` (0 rise, 1 fall) to `cal_data`.
- R9: Edges that arrive before the first `cyc_start` are ignored, and the first `cyc_start` produces no output.
- R10: An edge presented in the same clock as `cyc_start` is measured against the new `cyc_ts` and belongs to the new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Conversion cycle start pulse |
| cyc_ts | input | 16 | Timestamp of the cycle start |
| ev_valid | input | 1 | Comparator edge present |
| ev_ch | input | 4 | Channel of the edge |
| ev_lead | input | 1 | 1 = leading edge, 0 = trailing edge |
| ev_ts | input | 16 | Timestamp of the edge |
| cal_we | input | 1 | Calibration write enable |
| cal_dir | input | 1 | Table select, 0 rise, 1 fall |
| cal_idx | input | 5 | Breakpoint index 0..16 |
| cal_data | input | 12 | Breakpoint code |
| glitch_ch | input | 4 | Channel whose glitch count is shown |
| glitch_cnt | output | 8 | Glitch count of that channel |
| m_valid | output | 1 | Sample available |
| m_ready | input | 1 | Sample accepted |
| m_ch | output | 4 | Sample channel |
| m_dir | output | 1 | Sample ramp direction |
| m_ovf | output | 1 | No edge captured |
| m_code | output | 12 | Calibrated voltage code |

## Verification
The bench covers timestamp wraparound and the 4095/4096 phase boundary. A design that subtracted without wrapping, or that put the peak step in the wrong phase, would report wrong times or false overflows there. Wrong-polarity edges, repeated edges and a burst of 260 repeats check that the first edge wins, that the polarity filter does not count as a glitch, and that the counter saturates rather than wrapping to a small value. A nonlinear table, including a falling one, exercises the interpolation. It also exercises the t=4095 end point, where an index that wraps past the last segment would read the wrong breakpoint. Other tests cover back-pressure, an edge arriving in the same clock as a cycle start, and edges before the first start, which catch designs that drop, reorder or misattribute samples.

// File: rtl/ramp_seq.sv
module ramp_seq #(
  parameter int NCH = 16,
  parameter int TSW = 16,
  parameter int CW  = 12,
  parameter int NBP = 17,
  parameter int GW  = 8,
  localparam int CHW  = $clog2(NCH),
  localparam int BPW  = $clog2(NBP),
  localparam int SEGB = $clog2(NBP - 1),
  localparam int FB   = CW - SEGB,
  localparam int IDXW = $clog2(2 * NCH),
  localparam int PEAK = 1 << CW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cyc_start,
  input  logic [TSW-1:0] cyc_ts,
  input  logic           ev_valid,
  input  logic [CHW-1:0] ev_ch,
  input  logic           ev_lead,
  input  logic [TSW-1:0] ev_ts,
  input  logic           cal_we,
  input  logic           cal_dir,
  input  logic [BPW-1:0] cal_idx,
  input  logic [CW-1:0]  cal_data,
  input  logic [CHW-1:0] glitch_ch,
  output logic [GW-1:0]  glitch_cnt,
  output logic           m_valid,
  input  logic           m_ready,
  output logic [CHW-1:0] m_ch,
  output logic           m_dir,
  output logic           m_ovf,
  output logic [CW-1:0]  m_code
);

  logic            armed, busy;
  logic [TSW-1:0]  start_ts;
  logic [IDXW-1:0] idx;
  logic [CW-1:0]   cal   [2][NBP];
  logic [CW-1:0]   cap_t [2][NCH];
  logic [CW-1:0]   out_t [2][NCH];
  logic [NCH-1:0]  cap_v [2];
  logic [NCH-1:0]  out_v [2];
  logic [GW-1:0]   gcnt  [NCH];

  wire [TSW-1:0] el  = ev_ts - (cyc_start ? cyc_ts : start_ts);
  wire           ph  = el >= TSW'(PEAK);
  wire [TSW-1:0] el2 = ph ? el - TSW'(PEAK) : el;
  wire [CW-1:0]  tq  = (el2 >= TSW'(PEAK)) ? CW'(PEAK - 1) : el2[CW-1:0];
  wire           take = ev_valid && (armed || cyc_start) && (ev_lead != ph);
  wire           dup  = !cyc_start && cap_v[ph][ev_ch];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      start_ts <= '0;
      cap_v[0] <= '0;
      cap_v[1] <= '0;
      for (int c = 0; c < NCH; c++) gcnt[c] <= '0;
    end else begin
      if (cyc_start) begin
        armed    <= 1'b1;
        start_ts <= cyc_ts;
        cap_v[0] <= '0;
        cap_v[1] <= '0;
      end
      if (take) begin
        if (dup) begin
          if (gcnt[ev_ch] != '1) gcnt[ev_ch] <= gcnt[ev_ch] + 1'b1;
        end else begin
          cap_v[ph][ev_ch] <= 1'b1;
          cap_t[ph][ev_ch] <= tq;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (cyc_start && armed) begin
      busy     <= 1'b1;
      idx      <= '0;
      out_v[0] <= cap_v[0];
      out_v[1] <= cap_v[1];
      out_t    <= cap_t;
    end else if (busy && m_ready) begin
      if (idx == IDXW'(2 * NCH - 1)) busy <= 1'b0;
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int k = 0; k < NBP; k++)
          cal[b][k] <= (k * (1 << FB) > PEAK - 1) ? CW'(PEAK - 1) : CW'(k * (1 << FB));
    end else if (cal_we && cal_idx < BPW'(NBP)) begin
      cal[cal_dir][cal_idx] <= cal_data;
    end
  end

  assign glitch_cnt = gcnt[glitch_ch];
  assign m_valid    = busy;
  assign m_ch       = idx[IDXW-1:1];
  assign m_dir      = idx[0];

  logic [CW-1:0]          ot, y0, y1;
  logic [SEGB-1:0]        seg;
  logic [FB-1:0]          frac;
  logic signed [CW:0]     dy;
  logic signed [CW+FB+1:0] prod;

  always_comb begin
    ot    = out_t[m_dir][m_ch];
    m_ovf = !out_v[m_dir][m_ch];
    seg   = ot[CW-1:FB];
    frac  = ot[FB-1:0];
    y0    = cal[m_dir][BPW'(seg)];
    y1    = cal[m_dir][BPW'(seg) + 1'b1];
    dy    = $signed({1'b0, y1}) - $signed({1'b0, y0});
    prod  = dy * $signed({1'b0, frac});
    m_code = m_ovf ? '0 : y0 + CW'(prod >>> FB);
  end

endmodule

// File: rtl/ramp_seq_chk.sv
module ramp_seq_chk #(
  parameter int NCH = 16,
  parameter int CW  = 12,
  parameter int GW  = 8,
  localparam int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cyc_start,
  input logic           cal_we,
  input logic [CHW-1:0] glitch_ch,
  input logic [GW-1:0]  glitch_cnt,
  input logic           m_valid,
  input logic           m_ready,
  input logic [CHW-1:0] m_ch,
  input logic           m_dir,
  input logic           m_ovf,
  input logic [CW-1:0]  m_code
);

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !cyc_start && !cal_we) |=>
      (m_valid && $stable(m_ch) && $stable(m_dir) && $stable(m_ovf) && $stable(m_code)));

  a_r4_ovf_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ovf) |-> (m_code == '0));

  a_r5_first_is_ch0_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> (m_ch == '0 && !m_dir));

  a_r5_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(cyc_start));

  a_r5_dir_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && !cyc_start && !(m_ch == CHW'(NCH - 1) && m_dir)) |=>
      (m_valid && m_dir != $past(m_dir)));

  a_r3_glitch_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (glitch_ch != $past(glitch_ch) || glitch_cnt >= $past(glitch_cnt)));

endmodule

bind ramp_seq ramp_seq_chk #(.NCH(NCH), .CW(CW), .GW(GW)) u_chk (.*);

// File: tb/ramp_seq_bench.sv
module ramp_seq_bench;
  logic clk = 0, rst_n = 0;
  logic cyc_start = 0, ev_valid = 0, ev_lead = 0, cal_we = 0, cal_dir = 0, m_ready = 1;
  logic [15:0] cyc_ts = 0, ev_ts = 0;
  logic [3:0] ev_ch = 0, glitch_ch = 0, m_ch;
  logic [4:0] cal_idx = 0;
  logic [11:0] cal_data = 0, m_code;
  logic [7:0] glitch_cnt;
  logic m_valid, m_dir, m_ovf;

  int errors = 0, checks = 0;
  int calm [2][17];
  int et [2][16];
  int ev [2][16];
  int base;

  always #2.5 clk = ~clk;

  ramp_seq u_ramp_seq (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expcode(input int d, input int t);
    int s = t >>> 8, f = t & 255;
    return calm[d][s] + (((calm[d][s+1] - calm[d][s]) * f) >>> 8);
  endfunction

  task automatic clear_exp();
    for (int d = 0; d < 2; d++) for (int c = 0; c < 16; c++) ev[d][c] = 0;
  endtask

  task automatic send_ev(input int ch, input bit lead, input int ts);
    @(posedge clk); #1;
    ev_valid = 1; ev_ch = 4'(ch); ev_lead = lead; ev_ts = 16'(ts);
    @(posedge clk); #1;
    ev_valid = 0;
  endtask

  task automatic pulse_start(input int ts, input bit with_ev, input int ch, input int ets);
    @(posedge clk); #1;
    cyc_start = 1; cyc_ts = 16'(ts);
    if (with_ev) begin ev_valid = 1; ev_ch = 4'(ch); ev_lead = 1; ev_ts = 16'(ets); end
    @(posedge clk); #1;
    cyc_start = 0; ev_valid = 0;
  endtask

  task automatic cal_write(input bit d, input int k, input int v);
    @(posedge clk); #1;
    cal_we = 1; cal_dir = d; cal_idx = 5'(k); cal_data = 12'(v);
    @(posedge clk); #1;
    cal_we = 0;
    calm[d][k] = v;
  endtask

  task automatic drain(input string tag, input bit bp);
    int got = 0, guard = 0, cyc = 0;
    while (got < 32 && guard < 3000) begin
      @(negedge clk);
      m_ready = bp ? (cyc % 3 != 0) : 1'b1;
      cyc++;
      if (m_valid && m_ready) begin
        int c = got / 2, d = got % 2;
        int ex = ev[d][c] ? expcode(d, et[d][c]) : 0;
        chk(m_ch == 4'(c) && m_dir == d[0], {tag, " R5 order"}, m_ch * 2 + m_dir, got);
        chk(m_ovf == !ev[d][c], {tag, " R4 ovf"}, m_ovf, !ev[d][c]);
        chk(m_code == 12'(ex), {tag, " R7 code"}, m_code, ex);
        got++;
      end
      guard++;
    end
    chk(got == 32, {tag, " R6 sample count"}, got, 32);
    @(negedge clk);
    m_ready = 1;
    chk(!m_valid, {tag, " R6 valid drops after last"}, m_valid, 0);
  endtask

  task automatic t_reset();
    chk(!m_valid, "R5 reset valid", m_valid, 0);
    glitch_ch = 4'd5; #1;
    chk(glitch_cnt == 0, "R3 reset glitch", glitch_cnt, 0);
  endtask

  task automatic t_pre_arm();
    send_ev(0, 1, 100);
    pulse_start(1000, 0, 0, 0);
    base = 1000;
    repeat (3) @(negedge clk);
    chk(!m_valid, "R9 first start silent", m_valid, 0);
  endtask

  task automatic t_basic();
    clear_exp();
    for (int c = 0; c < 16; c++) begin
      et[0][c] = c * 251 + 7; ev[0][c] = 1;
      et[1][c] = c * 53 + 3;  ev[1][c] = 1;
      send_ev(c, 1, base + et[0][c]);
      send_ev(c, 0, base + 4096 + et[1][c]);
    end
    pulse_start(6000, 0, 0, 0);
    base = 6000;
    drain("basic R1 R8", 0);
  endtask

  task automatic t_polarity_glitch();
    clear_exp();
    for (int c = 0; c < 16; c += 2) begin
      et[0][c] = 300 + c; ev[0][c] = 1;
      send_ev(c, 1, base + et[0][c]);
    end
    send_ev(3, 0, base + 50);
    send_ev(3, 1, base + 4096 + 50);
    send_ev(5, 1, base + 10);
    send_ev(5, 1, base + 20);
    send_ev(5, 0, base + 4096 + 30);
    send_ev(5, 0, base + 4096 + 40);
    et[0][5] = 10; ev[0][5] = 1; et[1][5] = 30; ev[1][5] = 1;
    pulse_start(11000, 1, 7, 11000 + 77);
    base = 11000;
    drain("polarity R2", 0);
    glitch_ch = 4'd5; #1;
    chk(glitch_cnt == 2, "R3 glitch count ch5", glitch_cnt, 2);
    glitch_ch = 4'd3; #1;
    chk(glitch_cnt == 0, "R2 wrong polarity no glitch", glitch_cnt, 0);
  endtask

  task automatic t_boundary();
    clear_exp();
    et[0][7] = 77; ev[0][7] = 1;
    send_ev(0, 0, base + 4096 + 5000 + 4000);
    et[1][0] = 4095; ev[1][0] = 1;
    send_ev(1, 1, base + 4095);
    et[0][1] = 4095; ev[0][1] = 1;
    send_ev(2, 1, base + 4096);
    send_ev(2, 0, base + 4096);
    et[1][2] = 0; ev[1][2] = 1;
    for (int i = 0; i < 260; i++) send_ev(9, 1, base + 100 + i);
    et[0][9] = 100; ev[0][9] = 1;
    pulse_start(65000, 0, 0, 0);
    base = 65000;
    drain("boundary R10 R1", 0);
    glitch_ch = 4'd9; #1;
    chk(glitch_cnt == 255, "R3 glitch saturates", glitch_cnt, 255);
  endtask

  task automatic t_nonlinear();
    clear_exp();
    for (int k = 0; k < 17; k++) begin
      cal_write(0, k, k * k * 15);
      cal_write(1, k, 4095 - k * 200);
    end
    for (int c = 0; c < 16; c++) begin
      et[0][c] = c * 256 + c * 15; ev[0][c] = 1;
      if (c != 4) begin
        et[1][c] = c * 61 + 200; ev[1][c] = 1;
        send_ev(c, 0, base + 4096 + et[1][c]);
      end
      send_ev(c, 1, base + et[0][c]);
    end
    pulse_start(4000, 0, 0, 0);
    base = 4000;
    drain("nonlinear wrap R8 R1 R6", 1);
  endtask

  initial begin
    for (int d = 0; d < 2; d++)
      for (int k = 0; k < 17; k++) calm[d][k] = (k * 256 > 4095) ? 4095 : k * 256;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pre_arm();
    t_basic();
    t_polarity_glitch();
    t_boundary();
    t_nonlinear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule